// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Ripple Blanking

This block turns packed BCD digits into active-low seven-segment drive for a multi-digit numeric display. Each position has its own decoder cell with a lamp-test input, a ripple-blank input, a blanking input and a ripple-blank output. The wrapper links the cells so that zeros with no value are darkened. On the integer side, blanking runs from the most significant digit downward and stops at the first nonzero digit. On the fractional side, it runs from the least significant digit upward. The units digit is never suppressed, so a value of zero still reads as a single 0.

The default display has four integer and two fractional positions. Both counts are parameters. Leading and trailing suppression each have their own enable. A global blanking input darkens the whole display, and a lamp-test input lights every segment. The ripple-blank output of every position is brought out, so a further display can be chained onto this one.

Top module: `bcd7_display`

## Requirements
- R1: Segment bus bit 0 drives segment a and bit 6 drives segment g. Bits 1 to 5 drive b, c, d, e and f in that order. A 0 lights a segment. Codes 0 to 9 light these segments:
  - 0: abcdef
  - 1: bc
  - 2: abdeg
  - 3: abcdg
  - 4: bcfg
  - 5: acdfg
  - 6: acdefg
  - 7: abc
  - 8: all seven
  - 9: abcdfg
- R2: Codes 10 to 15 light only segment g, so the pattern is 7'b0111111. They never light all seven segments.
- R3: A cell whose ripple-blank input is low and whose code is 0 goes fully dark and drives its ripple-blank output low, unless lamp test is active. Otherwise the output is high.
- R4: While blank_n is low, every segment in every position is dark and every ripple-blank output is low, whatever the other inputs are.
- R5: While lamp_test_n is low and blank_n is high, every segment of every position is lit and every ripple-blank output is high, even for zeros that would otherwise be suppressed.
- R6: With lead_en high, an integer position above the units digit is dark when it and every more significant integer digit are 0. The units digit is always shown.
- R7: With trail_en high, a fractional position is dark when it and every less significant fractional digit are 0.
- R8: With lead_en low, no integer zero is suppressed. With trail_en low, no fractional zero is suppressed.
- R9: Bit k of blank_chain_n is low exactly when position k is blanked by the ripple chain or by blank_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digits_i | input | 4*(INT_DIGITS+FRAC_DIGITS) | BCD code per position. Nibble k is position k. Position 0 is the least significant fractional digit, and position FRAC_DIGITS is the units digit |
| lamp_test_n | input | 1 | Active-low lamp test |
| blank_n | input | 1 | Active-low global blanking |
| lead_en | input | 1 | Enables leading-zero suppression |
| trail_en | input | 1 | Enables trailing-zero suppression |
| seg_n_o | output | 7*(INT_DIGITS+FRAC_DIGITS) | Active-low segments. Bits 7k to 7k+6 belong to position k |
| blank_chain_n | output | INT_DIGITS+FRAC_DIGITS | Ripple-blank output of each position |

## Verification
The checks inside each cell take their inputs as settled two-state values. They judge a cell only by its own code, lamp-test, ripple-blank and blanking inputs, so they make no assumption about which neighbour feeds the chain. The checks also expect out-of-range codes to reach a cell, and the stimulus drives them on purpose: every code from 0 to 15 is placed on the units digit. The bench changes inputs only between samples and lets the chain settle before reading, so a half-rippled chain is never judged.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;

   typedef logic [6:0] seg_t;   // bit 0 = a ... bit 6 = g, active low

   localparam seg_t SEG_DARK = 7'h7F;
   localparam seg_t SEG_FULL = 7'h00;

   // Lit segments in active-high form, then inverted for the pins.
   function automatic seg_t glyph_n(input logic [3:0] code);
      logic [6:0] lit;
      case (code)
         4'd0:    lit = 7'h3F;
         4'd1:    lit = 7'h06;
         4'd2:    lit = 7'h5B;
         4'd3:    lit = 7'h4F;
         4'd4:    lit = 7'h66;
         4'd5:    lit = 7'h6D;
         4'd6:    lit = 7'h7D;
         4'd7:    lit = 7'h07;
         4'd8:    lit = 7'h7F;
         4'd9:    lit = 7'h6F;
         default: lit = 7'h40;   // out-of-range code: middle bar only
      endcase
      return ~lit;
   endfunction

endpackage

// File: rtl/bcd7_cell.sv
module bcd7_cell
   import bcd7_pkg::*;
(
   input  logic [3:0] code_i,
   input  logic       lamp_n_i,
   input  logic       rbi_n_i,
   input  logic       bi_n_i,
   output seg_t       seg_n_o,
   output logic       rbo_n_o
);

   logic zero_hit;

   always_comb begin
      zero_hit = (code_i == 4'd0) && !rbi_n_i && lamp_n_i;
      if (!bi_n_i) begin
         seg_n_o = SEG_DARK;
         rbo_n_o = 1'b0;
      end else if (!lamp_n_i) begin
         seg_n_o = SEG_FULL;
         rbo_n_o = 1'b1;
      end else if (zero_hit) begin
         seg_n_o = SEG_DARK;
         rbo_n_o = 1'b0;
      end else begin
         seg_n_o = glyph_n(code_i);
         rbo_n_o = 1'b1;
      end

      AST_BLANK_DARK: assert (bi_n_i || (seg_n_o == 7'h7F && !rbo_n_o)); // R4
      AST_LAMP_FULL: assert (!bi_n_i || lamp_n_i || (seg_n_o == 7'h00 && rbo_n_o)); // R5
      AST_RIPPLE_ZERO: assert (!bi_n_i || !lamp_n_i || rbi_n_i || code_i != 4'd0
                               || (seg_n_o == 7'h7F && !rbo_n_o)); // R3
      AST_RBO_ONLY_WHEN_DARK: assert (rbo_n_o || seg_n_o == 7'h7F); // R9
      AST_BAD_CODE_NOT_FULL: assert (!bi_n_i || !lamp_n_i || code_i < 4'd10
                                     || seg_n_o != 7'h00); // R2
   end

endmodule

// File: rtl/bcd7_display.sv
module bcd7_display
   import bcd7_pkg::*;
#(
   parameter int INT_DIGITS  = 4,
   parameter int FRAC_DIGITS = 2
) (
   input  logic [4*(INT_DIGITS+FRAC_DIGITS)-1:0] digits_i,
   input  logic                                  lamp_test_n,
   input  logic                                  blank_n,
   input  logic                                  lead_en,
   input  logic                                  trail_en,
   output logic [7*(INT_DIGITS+FRAC_DIGITS)-1:0] seg_n_o,
   output logic [INT_DIGITS+FRAC_DIGITS-1:0]     blank_chain_n
);

   localparam int NUM   = INT_DIGITS + FRAC_DIGITS;
   localparam int UNITS = FRAC_DIGITS;

   if (INT_DIGITS < 1) begin : g_bad_int
      $error("bcd7_display: INT_DIGITS must be at least 1");
   end
   if (FRAC_DIGITS < 0) begin : g_bad_frac
      $error("bcd7_display: FRAC_DIGITS must not be negative");
   end

   logic [NUM-1:0] chain_n;

   for (genvar k = 0; k < NUM; k++) begin : g_pos
      logic rbi_n;

      if (k == UNITS) begin : g_units
         assign rbi_n = 1'b1;              // units digit always shown
      end else if (k == NUM - 1) begin : g_msd
         assign rbi_n = ~lead_en;          // head of the leading chain
      end else if (k > UNITS) begin : g_int
         assign rbi_n = chain_n[k+1];      // fed from the next higher digit
      end else if (k == 0) begin : g_lsd
         assign rbi_n = ~trail_en;         // head of the trailing chain
      end else begin : g_frac
         assign rbi_n = chain_n[k-1];      // fed from the next lower digit
      end

      bcd7_cell u_cell (
         .code_i   (digits_i[4*k +: 4]),
         .lamp_n_i (lamp_test_n),
         .rbi_n_i  (rbi_n),
         .bi_n_i   (blank_n),
         .seg_n_o  (seg_n_o[7*k +: 7]),
         .rbo_n_o  (chain_n[k])
      );
   end

   assign blank_chain_n = chain_n;

endmodule

// File: tb/bcd7_display_bench.sv
module bcd7_display_bench;

   localparam int ND = 6;

   logic            clk = 1'b0;
   logic [4*ND-1:0] digits;
   logic            lamp_n, blk_n, lead, trail;
   logic [7*ND-1:0] seg_n;
   logic [ND-1:0]   chain_n;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   bcd7_display #(.INT_DIGITS(4), .FRAC_DIGITS(2)) u_bcd7_display (
      .digits_i      (digits),
      .lamp_test_n   (lamp_n),
      .blank_n       (blk_n),
      .lead_en       (lead),
      .trail_en      (trail),
      .seg_n_o       (seg_n),
      .blank_chain_n (chain_n)
   );

   // digits (pos5..pos0), expected dark mask with both suppressions on
   localparam logic [29:0] VEC [11] = '{
      {24'h000000, 6'b111011}, {24'h001250, 6'b110001}, {24'h100205, 6'b000000},
      {24'h010000, 6'b100011}, {24'h000005, 6'b111000}, {24'h000710, 6'b111001},
      {24'h999999, 6'b000000}, {24'h030040, 6'b100001}, {24'h100000, 6'b000011},
      {24'h000050, 6'b111001}, {24'h0A0300, 6'b100011}
   };

   function automatic logic [6:0] want_glyph(input logic [3:0] c);
      logic [6:0] on;   // {g,f,e,d,c,b,a} lit = 1
      case (c)
         0: on = 7'b0111111;  1: on = 7'b0000110;  2: on = 7'b1011011;
         3: on = 7'b1001111;  4: on = 7'b1100110;  5: on = 7'b1101101;
         6: on = 7'b1111101;  7: on = 7'b0000111;  8: on = 7'b1111111;
         9: on = 7'b1101111;  default: on = 7'b1000000;
      endcase
      return ~on;
   endfunction

   function automatic logic [7*ND-1:0] want_segs(input logic [23:0] d, input logic [5:0] dark);
      logic [7*ND-1:0] r;
      for (int k = 0; k < ND; k++)
         r[7*k +: 7] = dark[k] ? 7'h7F : want_glyph(d[4*k +: 4]);
      return r;
   endfunction

   task automatic apply(input logic [23:0] d, input logic lt, input logic bl,
                        input logic le, input logic te);
      @(negedge clk);
      digits = d; lamp_n = lt; blk_n = bl; lead = le; trail = te;
      #2;
   endtask

   task automatic chk_seg(input string req, input logic [7*ND-1:0] exp);
      checks++;
      if (seg_n !== exp) begin
         fails++;
         $display("FAIL %s segs: got %h expected %h", req, seg_n, exp);
      end
   endtask

   task automatic chk_chain(input string req, input logic [ND-1:0] exp);
      checks++;
      if (chain_n !== exp) begin
         fails++;
         $display("FAIL %s chain: got %b expected %b", req, chain_n, exp);
      end
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R4: idle state with blanking held
      apply(24'h888888, 1'b1, 1'b0, 1'b1, 1'b1);
      chk_seg("R4 idle", {7*ND{1'b1}});
      chk_chain("R4 idle", 6'b000000);

      // R6 R7: table of suppression patterns
      for (int v = 0; v < 11; v++) begin
         apply(VEC[v][29:6], 1'b1, 1'b1, 1'b1, 1'b1);
         chk_seg("R6/R7 table", want_segs(VEC[v][29:6], VEC[v][5:0]));
      end

      // R9, R3: chain outputs
      apply(24'h001250, 1'b1, 1'b1, 1'b1, 1'b1);
      chk_chain("R9 001250", 6'b001110);
      apply(24'h000000, 1'b1, 1'b1, 1'b1, 1'b1);
      chk_chain("R3 all zero", 6'b000100);

      // R1 R2: every code on the units digit
      for (int c = 0; c < 16; c++) begin
         apply({12'h000, c[3:0], 8'h00}, 1'b1, 1'b1, 1'b1, 1'b1);
         chk_seg(c < 10 ? "R1 glyph" : "R2 bad code",
                 want_segs({12'h000, c[3:0], 8'h00}, 6'b111011));
      end

      // R5: lamp test overrides ripple blanking
      apply(24'h000000, 1'b0, 1'b1, 1'b1, 1'b1);
      chk_seg("R5 lamp", {7*ND{1'b0}});
      chk_chain("R5 lamp", 6'b111111);

      // R4: blanking beats lamp test
      apply(24'h000000, 1'b0, 1'b0, 1'b1, 1'b1);
      chk_seg("R4 blank over lamp", {7*ND{1'b1}});

      // R8: suppression disabled
      apply(24'h000000, 1'b1, 1'b1, 1'b0, 1'b0);
      chk_seg("R8 both off", want_segs(24'h000000, 6'b000000));
      chk_chain("R8 both off", 6'b111111);
      apply(24'h001250, 1'b1, 1'b1, 1'b1, 1'b0);
      chk_seg("R8 trail off", want_segs(24'h001250, 6'b110000));
      apply(24'h001250, 1'b1, 1'b1, 1'b0, 1'b1);
      chk_seg("R8 lead off", want_segs(24'h001250, 6'b000001));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule